// File: doc/BRIEF.md
# Serial Interface Interrupt Control Register

This block holds the interrupt and enable control of a serial communication interface, together with the status flags that the transmitter and receiver raise and the three interrupt request lines built from them. A host reaches two 8-bit registers through a plain strobe bus: a control register at one address and a status register at another. The shifting engines and baud logic sit outside; they send single-cycle event pulses when transmit data is handed to the shift register, when a received byte lands in the receive data register, and when a framing, parity or overrun error is seen.

Each status flag follows a read-then-clear discipline: software must first read the status register while the flag is 1, and only then does a write of 0 to that bit clear it. A hardware event in the same cycle as such a clear wins and demands a fresh read. The transmit request follows the transmit enable and the transmit-empty flag; the receive-full and receive-error requests share one enable. The request lines are combinational from the stored enables and flags.

Top module: `sci_irq_ctrl`

## Requirements
- R1: The control register (address 0) holds 8 bits, every one writable and readable; fields from bit 7 down: transmit interrupt enable, receive interrupt enable, transmitter enable, receiver enable, multiprocessor interrupt enable, transmit-end interrupt enable, clock select [1:0]. Read data appears on rdata_o in the cycle after the read strobe.
- R2: The control register becomes 0x00 on reset and on every cycle that standby_i is 1, which also overrides a write in that cycle.
- R3: The status register (address 1) reads transmit-empty at bit 7, receive-full at bit 6, overrun at bit 5, framing at bit 4, parity at bit 3, and 0 in bits 2:0; after reset it reads 0x80.
- R4: Each event pulse sets its flag: tx_load_i sets transmit-empty, rx_ready_i sets receive-full, overrun_i, frame_err_i and parity_err_i set the error flags.
- R5: txi_o is 1 exactly when the transmit interrupt enable and the transmit-empty flag are both 1.
- R6: rxi_o is 1 exactly when the receive interrupt enable and the receive-full flag are both 1.
- R7: eri_o is 1 exactly when the receive interrupt enable is 1 and any error flag is 1; the transmit interrupt enable has no effect on it.
- R8: Writing 0 to a flag clears it only if the status register was read with that flag at 1 since the flag was last set; otherwise the write leaves the flag at 1.
- R9: Writing 1 to a status flag bit leaves that flag unchanged.
- R10: A set event in the same cycle as a valid clear keeps the flag at 1, and a new read is needed before a later write of 0 clears it.
- R11: Clearing an interrupt enable drops its request lines at once and leaves the status flags unchanged.
- R12: tx_en_o, rx_en_o, mp_ie_o, tend_ie_o and clk_sel_o show the current values of the matching control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby; forces control register to zero |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| tx_load_i | input | 1 | Transmit data moved to shift register |
| rx_ready_i | input | 1 | Received byte moved to data register |
| frame_err_i | input | 1 | Framing error event |
| parity_err_i | input | 1 | Parity error event |
| overrun_i | input | 1 | Overrun error event |
| txi_o | output | 1 | Transmit-empty interrupt request |
| rxi_o | output | 1 | Receive-full interrupt request |
| eri_o | output | 1 | Receive-error interrupt request |
| tx_en_o | output | 1 | Transmitter enable field |
| rx_en_o | output | 1 | Receiver enable field |
| mp_ie_o | output | 1 | Multiprocessor interrupt enable field |
| tend_ie_o | output | 1 | Transmit-end interrupt enable field |
| clk_sel_o | output | 2 | Clock select field |

## Verification
The clear discipline is driven with three patterns: a write of 0 after a read that saw the flag set, a write of 0 to a flag set after the last read, and a write mixing 0s and 1s, which together separate per-flag arming from a single shared arm and from write-one-to-clear behaviour. Request lines are checked while enables and flags are toggled in both orders, with each error source raised alone so a missing term in the error OR shows up, and with only the transmit enable on so a wrong enable on the error request is caught. A set event coinciding with a valid clear, followed by an unread second clear, distinguishes set priority and re-arming from plain last-writer-wins.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int NFLAG    = 5;
  localparam int FLAG_LSB = DATA_W - NFLAG;

  // flag indices; status bit position = FLAG_LSB + index
  localparam int FL_PER  = 0;
  localparam int FL_FER  = 1;
  localparam int FL_ORER = 2;
  localparam int FL_RDRF = 3;
  localparam int FL_TDRE = 4;

  typedef struct packed {
    logic       tx_ie;
    logic       rx_ie;
    logic       tx_en;
    logic       rx_en;
    logic       mp_ie;
    logic       tend_ie;
    logic [1:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/sci_ctrl_reg.sv
module sci_ctrl_reg
  import sci_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst || standby_i) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q <= ctrl_t'(wdata_i);
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/sci_flag_cell.sv
module sci_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;
  logic do_clr;

  // clear needs a write of 0 after a read that saw the flag at 1
  assign do_clr = wr_i && !wbit_i && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      if (set_i) begin
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (do_clr) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (rd_i && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sci_irq_req.sv
module sci_irq_req
  import sci_irq_pkg::*;
(
  input  ctrl_t            ctrl_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic             txi_o,
  output logic             rxi_o,
  output logic             eri_o
);
  logic any_err;

  assign any_err = flags_i[FL_ORER] | flags_i[FL_FER] | flags_i[FL_PER];
  assign txi_o   = ctrl_i.tx_ie & flags_i[FL_TDRE];
  assign rxi_o   = ctrl_i.rx_ie & flags_i[FL_RDRF];
  assign eri_o   = ctrl_i.rx_ie & any_err;
endmodule

// File: rtl/sci_irq_ctrl.sv
module sci_irq_ctrl
  import sci_irq_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_load_i,
  input  logic              rx_ready_i,
  input  logic              frame_err_i,
  input  logic              parity_err_i,
  input  logic              overrun_i,
  output logic              txi_o,
  output logic              rxi_o,
  output logic              eri_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              mp_ie_o,
  output logic              tend_ie_o,
  output logic [1:0]        clk_sel_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic              ctrl_sel, stat_sel, stat_wr, stat_rd;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] ctrl_q, stat_q;
  logic [NFLAG-1:0]  evt, flags;

  assign ctrl_sel = (addr_i == CTRL_A);
  assign stat_sel = (addr_i == STAT_A);
  assign stat_wr  = wr_i && stat_sel;
  assign stat_rd  = rd_i && stat_sel;

  sci_ctrl_reg ctrl_reg_i (
    .clk      (clk),
    .rst      (rst),
    .standby_i(standby_i),
    .wr_en_i  (wr_i && ctrl_sel),
    .wdata_i  (wdata_i),
    .ctrl_o   (ctrl)
  );

  assign ctrl_q = ctrl;

  assign evt[FL_TDRE] = tx_load_i;
  assign evt[FL_RDRF] = rx_ready_i;
  assign evt[FL_ORER] = overrun_i;
  assign evt[FL_FER]  = frame_err_i;
  assign evt[FL_PER]  = parity_err_i;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sci_flag_cell #(
      .RST_VAL((g == FL_TDRE) ? 1'b1 : 1'b0)
    ) cell_i (
      .clk   (clk),
      .rst   (rst),
      .set_i (evt[g]),
      .rd_i  (stat_rd),
      .wr_i  (stat_wr),
      .wbit_i(wdata_i[FLAG_LSB+g]),
      .flag_o(flags[g])
    );
  end

  assign stat_q = {flags, {FLAG_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if (ctrl_sel)      rdata_o <= ctrl_q;
      else if (stat_sel) rdata_o <= stat_q;
      else               rdata_o <= '0;
    end
  end

  sci_irq_req req_i (
    .ctrl_i (ctrl),
    .flags_i(flags),
    .txi_o  (txi_o),
    .rxi_o  (rxi_o),
    .eri_o  (eri_o)
  );

  assign tx_en_o   = ctrl.tx_en;
  assign rx_en_o   = ctrl.rx_en;
  assign mp_ie_o   = ctrl.mp_ie;
  assign tend_ie_o = ctrl.tend_ie;
  assign clk_sel_o = ctrl.clk_sel;
endmodule

// File: rtl/sci_irq_ctrl_chk.sv
module sci_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       standby_i,
  input logic       tx_load_i,
  input logic       rx_ready_i,
  input logic       stat_wr_i,
  input logic       wd7_i,
  input logic       wd6_i,
  input logic [7:0] ctrl_q,
  input logic       tdre_q,
  input logic       rdrf_q,
  input logic       txi_o,
  input logic       rxi_o,
  input logic       eri_o
);
  // R2
  standby_clr_chk: assert property (@(posedge clk) disable iff (rst)
    standby_i |=> (ctrl_q == 8'h00));

  // R4
  rx_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready_i |=> rdrf_q);

  // R10
  tx_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_load_i && stat_wr_i && !wd7_i) |=> tdre_q);

  // R8
  rdrf_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdrf_q) |-> $past(stat_wr_i && !wd6_i));

  // R9
  rdrf_wr1_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr_i && wd6_i && !rx_ready_i) |=> (rdrf_q == $past(rdrf_q)));

  // R11
  rie_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[6] |-> (!rxi_o && !eri_o));

  // R5
  txi_en_chk: assert property (@(posedge clk) disable iff (rst)
    txi_o |-> ctrl_q[7]);
endmodule

bind sci_irq_ctrl sci_irq_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .standby_i (standby_i),
  .tx_load_i (tx_load_i),
  .rx_ready_i(rx_ready_i),
  .stat_wr_i (stat_wr),
  .wd7_i     (wdata_i[7]),
  .wd6_i     (wdata_i[6]),
  .ctrl_q    (ctrl_q),
  .tdre_q    (stat_q[7]),
  .rdrf_q    (stat_q[6]),
  .txi_o     (txi_o),
  .rxi_o     (rxi_o),
  .eri_o     (eri_o)
);

// File: tb/sci_irq_ctrl_tb.sv
module sci_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;
  localparam logic [4:0] E_TX = 5'b10000, E_RX = 5'b01000, E_OV = 5'b00100,
                         E_FR = 5'b00010, E_PA = 5'b00001, E_NO = 5'b00000;

  // {op, addr, data, evt{tx,rx,ovr,frm,par}, irq{txi,rxi,eri}, exp rdata, req}
  localparam logic [31:0] VEC [NVEC] = '{
    {OP_RD, 2'd0, 8'h00, E_NO, 3'b000, 8'h00, 4'd1},  // R1 ctrl after reset
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b000, 8'h80, 4'd3},  // R3 status after reset
    {OP_WR, 2'd0, 8'hA5, E_NO, 3'b100, 8'h00, 4'd5},  // R5 TIE with TDRE
    {OP_RD, 2'd0, 8'h00, E_NO, 3'b100, 8'hA5, 4'd1},  // R1 readback
    {OP_EV, 2'd0, 8'h00, E_RX, 3'b100, 8'h00, 4'd6},  // R6 RDRF but RIE off
    {OP_WR, 2'd0, 8'hC0, E_NO, 3'b110, 8'h00, 4'd6},  // R6 RIE on
    {OP_EV, 2'd0, 8'h00, E_FR, 3'b111, 8'h00, 4'd7},  // R7 framing
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b111, 8'hD0, 4'd4},  // R4 flags set
    {OP_WR, 2'd1, 8'hEF, E_NO, 3'b110, 8'h00, 4'd8},  // R8 clear FER only
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b110, 8'hC0, 4'd9},  // R9 ones kept flags
    {OP_EV, 2'd0, 8'h00, E_PA, 3'b111, 8'h00, 4'd7},  // R7 parity
    {OP_WR, 2'd1, 8'h00, E_NO, 3'b001, 8'h00, 4'd8},  // R8 unread PER stays
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b001, 8'h08, 4'd8},
    {OP_WR, 2'd0, 8'h80, E_NO, 3'b000, 8'h00, 4'd11}, // R11 RIE off
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b000, 8'h08, 4'd11}, // R11 flags intact
    {OP_WR, 2'd0, 8'h40, E_NO, 3'b001, 8'h00, 4'd7},
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b001, 8'h08, 4'd3},
    {OP_EV, 2'd0, 8'h00, E_OV, 3'b001, 8'h00, 4'd4},
    {OP_WR, 2'd1, 8'h00, E_NO, 3'b001, 8'h00, 4'd8},
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b001, 8'h20, 4'd7},  // R7 overrun alone
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b001, 8'h20, 4'd4},
    {OP_WR, 2'd1, 8'h00, E_NO, 3'b000, 8'h00, 4'd8},
    {OP_RD, 2'd1, 8'h00, E_NO, 3'b000, 8'h00, 4'd8},
    {OP_EV, 2'd0, 8'h00, E_TX, 3'b000, 8'h00, 4'd5},  // R5 TDRE, TIE off
    {OP_WR, 2'd0, 8'hFF, E_NO, 3'b100, 8'h00, 4'd5},
    {OP_RD, 2'd0, 8'h00, E_NO, 3'b100, 8'hFF, 4'd1}
  };

  logic       clk = 1'b0, rst = 1'b1, standby = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_load = 1'b0, rx_ready = 1'b0, frame_err = 1'b0,
              parity_err = 1'b0, overrun = 1'b0;
  logic       txi, rxi, eri, tx_en, rx_en, mp_ie, tend_ie;
  logic [1:0] clk_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sci_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .standby_i(standby), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .tx_load_i(tx_load),
    .rx_ready_i(rx_ready), .frame_err_i(frame_err), .parity_err_i(parity_err),
    .overrun_i(overrun), .txi_o(txi), .rxi_o(rxi), .eri_o(eri),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .mp_ie_o(mp_ie), .tend_ie_o(tend_ie),
    .clk_sel_o(clk_sel)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [1:0] op, input logic [1:0] a,
                      input logic [7:0] d, input logic [4:0] ev, input bit sb,
                      input logic [2:0] exp_irq, input logic [7:0] exp_d,
                      input string tag);
    addr  = a;
    wdata = d;
    wr    = (op == OP_WR);
    rd    = (op == OP_RD);
    {tx_load, rx_ready, overrun, frame_err, parity_err} = ev;
    standby = sb;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; standby = 1'b0;
    {tx_load, rx_ready, overrun, frame_err, parity_err} = '0;
    check({txi, rxi, eri} == exp_irq, tag, {5'b0, txi, rxi, eri}, {5'b0, exp_irq});
    if (op == OP_RD) check(rdata == exp_d, tag, rdata, exp_d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][31:30], VEC[i][29:28], VEC[i][27:20], VEC[i][19:15], 1'b0,
           VEC[i][14:12], VEC[i][11:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R10: set event with a valid clear, then an unread clear
    step(OP_RD, 2'd1, 8'h00, E_NO, 1'b0, 3'b100, 8'h80, "R10 arm");
    step(OP_WR, 2'd1, 8'h00, E_TX, 1'b0, 3'b100, 8'h00, "R10 set wins");
    step(OP_WR, 2'd1, 8'h00, E_NO, 1'b0, 3'b100, 8'h00, "R10 needs reread");
    step(OP_RD, 2'd1, 8'h00, E_NO, 1'b0, 3'b100, 8'h80, "R10 still set");
    step(OP_WR, 2'd1, 8'h7F, E_NO, 1'b0, 3'b000, 8'h00, "R8 clear after reread");
    step(OP_RD, 2'd1, 8'h00, E_NO, 1'b0, 3'b000, 8'h00, "R8 cleared");

    // R12: control fields on pins (ctrl = FF, then 0x24)
    check({tx_en, rx_en, mp_ie, tend_ie, clk_sel} == 6'b111111, "R12 pins FF",
          {2'b0, tx_en, rx_en, mp_ie, tend_ie, clk_sel}, 8'h3F);
    step(OP_WR, 2'd0, 8'h24, E_NO, 1'b0, 3'b000, 8'h00, "R12 write 24");
    check({tx_en, rx_en, mp_ie, tend_ie, clk_sel} == 6'b100100, "R12 pins 24",
          {2'b0, tx_en, rx_en, mp_ie, tend_ie, clk_sel}, 8'h24);

    // R2: standby clears control, and beats a write in the same cycle
    step(OP_WR, 2'd0, 8'hFF, E_TX, 1'b0, 3'b100, 8'h00, "R2 setup");
    step(OP_EV, 2'd0, 8'h00, E_NO, 1'b1, 3'b000, 8'h00, "R2 standby irq");
    step(OP_RD, 2'd0, 8'h00, E_NO, 1'b0, 3'b000, 8'h00, "R2 standby ctrl");
    step(OP_WR, 2'd0, 8'hFF, E_NO, 1'b1, 3'b000, 8'h00, "R2 standby vs write");
    step(OP_RD, 2'd0, 8'h00, E_NO, 1'b0, 3'b000, 8'h00, "R2 write lost");
    step(OP_RD, 2'd1, 8'h00, E_NO, 1'b0, 3'b000, 8'h80, "R2 standby keeps flags");

    // R3: reset in mid-run
    step(OP_WR, 2'd0, 8'hC0, E_RX, 1'b0, 3'b110, 8'h00, "R3 setup");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check({txi, rxi, eri} == 3'b000, "R3 irq after reset", {5'b0, txi, rxi, eri}, 8'h00);
    step(OP_RD, 2'd1, 8'h00, E_NO, 1'b0, 3'b000, 8'h80, "R3 status reset");
    step(OP_RD, 2'd0, 8'h00, E_NO, 1'b0, 3'b000, 8'h00, "R2 ctrl reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule